// File: doc/BRIEF.md
# Streaming Write Allocation Mode Detector

The block watches write requests arriving at a cache and recognises a single sequential stream. It keeps the address where the next write of that stream should start and a count of the bytes written back-to-back so far. As the count grows, the block moves through three write policies: normal allocation, write merging (hold partial writes so that a whole line can be assembled), and no allocation (whole lines bypass the cache). Two advisory flags, `coalesce_o` and `allocate_o`, present the current policy to the cache controller.

Alongside the stream tracker sits a small table of per-line hold counters. When the controller has a partial-line write miss ready to issue, it asks the table whether that miss should wait one more turn so that further bytes can merge into it. The answer comes back combinationally in the cycle of the query. The controller clears a line's counter once the miss has been sent.

Top module: `wr_stream_mode`

## Requirements
- R1: After reset, and in the cycle after `flush_i` is high, the policy is normal allocation (`coalesce_o`=0, `allocate_o`=1), the byte count is zero and the expected address is zero. A flush overrides a write presented in the same cycle.
- R2: The flags encode the policy as: normal allocation {coalesce,allocate}={0,1}; merging {1,1}; no allocation {1,0}. The pair {0,0} never appears.
- R3: A write whose start address equals the expected address adds its size to the byte count and sets the expected address to start plus size (modulo 2^AW). When the count becomes strictly greater than CO_LINES*LINE_BYTES, the policy becomes merging.
- R4: When the count of a continuing stream becomes strictly greater than NA_LINES*LINE_BYTES, the policy becomes no allocation.
- R5: In no-allocation policy the byte count stops growing, and further continuing writes keep the policy at no allocation.
- R6: A write whose start address differs from the expected address returns the policy to normal allocation, restarts the count at that write's size and sets the expected address to start plus size.
- R7: The flags change only on the clock edge after a write or flush strobe; in cycles without either they hold their value.
- R8: The first query for a line not in the table loads its counter with DELAY and answers hold (when DELAY>0), storing DELAY-1; a later query for a line whose counter is nonzero answers hold and decrements it. With DELAY=2 a line is held on its first two queries.
- R9: A query for a line whose counter is zero answers release and leaves the counter at zero, so every later query also releases.
- R10: A clear for a line removes its entry, so the next query for that line starts again as in R8. A clear in the same cycle as a query of the same line lets the query answer from the state before the cycle, and the entry is gone afterwards.
- R11: The table holds DEPTH lines; a query for a new line is placed in allocation order and overwrites the oldest allocated entry, whose line then starts afresh on its next query.
- R12: `dly_hold_o` is 0 in every cycle without a query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Restart stream tracking (policy, count, expected address) |
| wr_valid_i | input | 1 | A write request is present this cycle |
| wr_addr_i | input | AW | Start byte address of the write |
| wr_size_i | input | SW | Size of the write in bytes |
| dly_query_i | input | 1 | Ask whether a write miss should be held |
| dly_line_i | input | AW | Line address of the queried miss |
| dly_clear_i | input | 1 | Remove a line's hold counter |
| dly_clear_line_i | input | AW | Line address to remove |
| dly_hold_o | output | 1 | Query answer: hold the miss another turn |
| coalesce_o | output | 1 | Policy is merging or no allocation |
| allocate_o | output | 1 | Policy is normal allocation or merging |

## Verification
A write strobe and a hold query are independent, so the bench issues both in the same cycle while a stream crosses its thresholds and judges the combinational hold answer and the next-cycle flags separately against arithmetic models of the count and the table. The second collision is a query and a clear of the same line in one cycle: the bench expects the answer from the prior counter and then a fresh load of DELAY on the following query. A flush together with a write is also driven, and normal allocation is expected with the write discarded.

// File: rtl/wr_stream_mode.sv
module wr_stream_mode #(
  parameter int AW         = 16,
  parameter int SW         = 6,
  parameter int LINE_BYTES = 16,
  parameter int CO_LINES   = 2,
  parameter int NA_LINES   = 4,
  parameter int DELAY      = 2,
  parameter int DEPTH      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [SW-1:0] wr_size_i,
  input  logic          dly_query_i,
  input  logic [AW-1:0] dly_line_i,
  input  logic          dly_clear_i,
  input  logic [AW-1:0] dly_clear_line_i,
  output logic          dly_hold_o,
  output logic          coalesce_o,
  output logic          allocate_o
);
  localparam int CO_BYTES = CO_LINES * LINE_BYTES;
  localparam int NA_BYTES = NA_LINES * LINE_BYTES;
  localparam int CW       = $clog2(NA_BYTES + (1 << SW)) + 1;
  localparam int DW       = $clog2(DELAY + 1) + 1;
  localparam int PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {M_ALLOC, M_MERGE, M_BYPASS} mode_t;

  mode_t         mode_q;
  logic [CW-1:0] count_q;
  logic [AW-1:0] next_q;

  wire           match = (wr_addr_i == next_q);
  wire  [CW-1:0] sum   = count_q + CW'(wr_size_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_ALLOC;
      count_q <= '0;
      next_q  <= '0;
    end else if (flush_i) begin
      mode_q  <= M_ALLOC;
      count_q <= '0;
      next_q  <= '0;
    end else if (wr_valid_i) begin
      next_q <= wr_addr_i + AW'(wr_size_i);
      if (!match) begin
        mode_q  <= M_ALLOC;
        count_q <= CW'(wr_size_i);
      end else if (mode_q != M_BYPASS) begin
        count_q <= sum;
        if (sum > CW'(NA_BYTES))      mode_q <= M_BYPASS;
        else if (sum > CW'(CO_BYTES)) mode_q <= M_MERGE;
      end
    end
  end

  assign coalesce_o = (mode_q != M_ALLOC);
  assign allocate_o = (mode_q != M_BYPASS);

  logic [DEPTH-1:0] v_q, v_d;
  logic [AW-1:0]    ln_q [DEPTH];
  logic [AW-1:0]    ln_d [DEPTH];
  logic [DW-1:0]    ct_q [DEPTH];
  logic [DW-1:0]    ct_d [DEPTH];
  logic [PW-1:0]    ptr_q, ptr_d;
  logic             hit;
  logic [PW-1:0]    hidx;

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (v_q[i] && ln_q[i] == dly_line_i) begin
        hit  = 1'b1;
        hidx = PW'(i);
      end
  end

  assign dly_hold_o = dly_query_i && (hit ? (ct_q[hidx] != '0) : (DELAY != 0));

  always_comb begin
    v_d   = v_q;
    ln_d  = ln_q;
    ct_d  = ct_q;
    ptr_d = ptr_q;
    if (dly_query_i) begin
      if (hit) begin
        if (ct_q[hidx] != '0) ct_d[hidx] = ct_q[hidx] - 1'b1;
      end else begin
        v_d[ptr_q]  = 1'b1;
        ln_d[ptr_q] = dly_line_i;
        ct_d[ptr_q] = (DELAY != 0) ? DW'(DELAY - 1) : '0;
        ptr_d       = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
    if (dly_clear_i)
      for (int i = 0; i < DEPTH; i++)
        if (v_d[i] && ln_d[i] == dly_clear_line_i) v_d[i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ln_q[i] <= '0;
        ct_q[i] <= '0;
      end
    end else begin
      v_q   <= v_d;
      ptr_q <= ptr_d;
      ln_q  <= ln_d;
      ct_q  <= ct_d;
    end
  end
endmodule

// File: rtl/wr_stream_mode_chk.sv
module wr_stream_mode_chk #(
  parameter int AW = 16,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_i,
  input logic          wr_valid_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [SW-1:0] wr_size_i,
  input logic          dly_query_i,
  input logic          dly_hold_o,
  input logic          coalesce_o,
  input logic          allocate_o,
  input logic [AW-1:0] next_q
);
  assert_flush_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (allocate_o && !coalesce_o));

  assert_flag_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (allocate_o || coalesce_o));

  assert_bypass_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !flush_i && wr_addr_i == next_q && !allocate_o) |=> !allocate_o);

  assert_break_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !flush_i && wr_addr_i != next_q) |=> (allocate_o && !coalesce_o));

  assert_flags_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid_i && !flush_i) |=> ($stable(coalesce_o) && $stable(allocate_o)));

  assert_hold_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_query_i |-> !dly_hold_o);
endmodule

bind wr_stream_mode wr_stream_mode_chk #(.AW(AW), .SW(SW)) i_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .wr_valid_i(wr_valid_i),
  .wr_addr_i(wr_addr_i), .wr_size_i(wr_size_i), .dly_query_i(dly_query_i),
  .dly_hold_o(dly_hold_o), .coalesce_o(coalesce_o), .allocate_o(allocate_o),
  .next_q(next_q)
);

// File: tb/test_wr_stream_mode.sv
module test_wr_stream_mode;
  localparam int T = 2, CO = 32, NA = 64;

  logic clk = 0, rst_n = 0, flush = 0, wv = 0, q = 0, c = 0;
  logic [15:0] wa = 0, ql = 0, cl = 0;
  logic [5:0]  ws = 0;
  logic hold, coal, alloc;
  int nchk = 0, nerr = 0;

  int m_mode = 0, m_cnt = 0, m_next = 0;
  bit m_v[4];
  int m_l[4], m_c[4], m_p = 0;

  always #5 clk = ~clk;

  wr_stream_mode i_wr_stream_mode (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .wr_valid_i(wv), .wr_addr_i(wa),
    .wr_size_i(ws), .dly_query_i(q), .dly_line_i(ql), .dly_clear_i(c),
    .dly_clear_line_i(cl), .dly_hold_o(hold), .coalesce_o(coal), .allocate_o(alloc)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int flags_exp();
    return ((m_mode != 0) ? 2 : 0) | ((m_mode != 2) ? 1 : 0);
  endfunction

  function automatic int tbl_query(int line);
    int ans = 0;
    bit found = 0;
    for (int i = 0; i < 4; i++)
      if (!found && m_v[i] && m_l[i] == line) begin
        found = 1;
        ans = (m_c[i] != 0);
        if (m_c[i] > 0) m_c[i]--;
      end
    if (!found) begin
      ans = (T != 0);
      m_v[m_p] = 1; m_l[m_p] = line; m_c[m_p] = (T > 0) ? T - 1 : 0;
      m_p = (m_p + 1) % 4;
    end
    return ans;
  endfunction

  task automatic step(bit w, int a, int s, bit f, bit dq, int dl, bit dc, int dcl, string qtag);
    int pm, exp_h;
    string ft;
    @(negedge clk);
    wv = w; wa = a[15:0]; ws = s[5:0]; flush = f;
    q = dq; ql = dl[15:0]; c = dc; cl = dcl[15:0];
    #1;
    if (dq) begin
      exp_h = tbl_query(dl);
      chk(qtag, hold, exp_h);
    end else chk("R12", hold, 0);
    if (dc)
      for (int i = 0; i < 4; i++) if (m_v[i] && m_l[i] == dcl) m_v[i] = 0;
    pm = m_mode;
    ft = "R7";
    if (f) begin
      m_mode = 0; m_cnt = 0; m_next = 0; ft = "R1";
    end else if (w) begin
      if (a != m_next) begin
        m_mode = 0; m_cnt = s; ft = "R6";
      end else if (m_mode != 2) begin
        m_cnt += s;
        if (m_cnt > NA) begin m_mode = 2; ft = "R4"; end
        else begin
          if (m_cnt > CO) m_mode = 1;
          ft = "R3";
        end
      end else ft = "R5";
      m_next = (a + s) & 16'hFFFF;
    end
    @(negedge clk);
    wv = 0; flush = 0; q = 0; c = 0;
    chk({ft, " R2"}, {coal, alloc}, flags_exp());
  endtask

  task automatic wr(int a, int s); step(1, a, s, 0, 0, 0, 0, 0, ""); endtask
  task automatic qry(int l, string tg); step(0, 0, 0, 0, 1, l, 0, 0, tg); endtask

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int a;
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_l[i] = 0; m_c[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 R2", {coal, alloc}, 1);
    chk("R12", hold, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {coal, alloc}, 1);

    // R1: expected address is zero after reset, stream crosses both thresholds
    a = 0;
    for (int k = 0; k < 22; k++) begin wr(a, 4); a += 4; end
    // R7: idle cycles keep the policy
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, "");
    // R6: break the stream
    wr(16'h1000, 8);
    wr(16'h1008, 8);

    // near-exhaustive sweep of sizes with a break in the middle
    for (int s = 1; s < 64; s += 3) begin
      step(0, 0, 0, 1, 0, 0, 0, 0, "");
      a = 16'h2000 + s * 16;
      wr(16'h0, s);                 // R1: zero address continues after flush
      a = s;
      for (int k = 0; k < (NA / s) + 3; k++) begin wr(a, s); a += s; end
      wr(a + 1, s);                 // R6
      a = a + 1 + s;
      for (int k = 0; k < (CO / s) + 2; k++) begin wr(a, s); a += s; end
    end

    // address wrap-around on a continuing stream (R3)
    step(0, 0, 0, 1, 0, 0, 0, 0, "");
    wr(16'hFFF0, 16);
    wr(16'h0000, 16);
    wr(16'h0010, 16);

    // R1: flush overrides a write in the same cycle
    wr(16'h0030, 40);
    step(1, 16'h0058, 40, 1, 0, 0, 0, 0, "");
    wr(16'h0000, 8);

    // delay table: R8 hold twice, R9 release afterwards
    qry(16'h0100, "R8");
    qry(16'h0100, "R8");
    qry(16'h0100, "R9");
    qry(16'h0100, "R9");
    // R10: clear then fresh start
    step(0, 0, 0, 0, 0, 0, 1, 16'h0100, "");
    qry(16'h0100, "R10");
    // R10: query and clear of the same line in one cycle
    step(0, 0, 0, 0, 1, 16'h0200, 1, 16'h0200, "R10");
    qry(16'h0200, "R10");
    // R11: fill and overflow the table, oldest is replaced
    for (int l = 0; l < 6; l++) qry(16'h0300 + l, "R11");
    for (int l = 0; l < 6; l++) qry(16'h0300 + l, "R11");
    // write strobe and query in the same cycle while the stream advances
    step(0, 0, 0, 1, 0, 0, 0, 0, "");
    a = 0;
    for (int k = 0; k < 20; k++) begin
      step(1, a, 5, 0, 1, 16'h0400 + (k % 6), 0, 0, "R8");
      a += 5;
    end
    // sweep of queries and clears over a small line set
    for (int k = 0; k < 60; k++)
      step(0, 0, 0, 0, 1, k % 7, (k % 5) == 0, (k * 3) % 7, "R11");

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule